// File: doc/BRIEF.md
# Daisy-Chain Priority Interrupt Network

This block arbitrates interrupts from several devices by passing an acknowledge token along a serial chain of identical stages. Each stage remembers that its device asked for service. The processor sees one combined interrupt line that is high while any stage has a pending request. When the processor raises its acknowledge, the token enters the stage nearest the processor and moves down the chain. It stops at the first stage that has a pending request. That stage places its own vector on the shared vector bus. Precedence comes only from position in the chain, so no central priority encoder is needed. Each stage holds its vector as a parameter.

On the clock edge after a stage has driven its vector, its pending flag clears. If the processor keeps acknowledge high, the next pending stage down the chain wins on the following cycle. Holding acknowledge therefore drains all pending requests in chain order.

Top module: `daisy_chain_irq`

## Requirements
- R1: A device request that is high at a rising clock edge sets that stage's pending flag. The flag stays set after the request falls, until the stage is serviced.
- R2: While `cpu_ack` is low, every bit of `vec_en` is 0, `chain_tail` is 0 and `vec_bus` is 0, whatever is pending.
- R3: While `cpu_ack` is high, a stage with nothing pending passes the token on. With nothing pending in any stage, `chain_tail` is 1 and `vec_bus` is 0.
- R4: While `cpu_ack` is high, the pending stage with the lowest index (index 0 sits next to the processor) is the only stage whose `vec_en` bit is 1, and `chain_tail` is 0.
- R5: While stage k holds the token, `vec_bus` equals VEC_BASE + k*VEC_STEP, truncated to VEC_W bits.
- R6: `cpu_int` is 1 exactly when at least one stage has a pending request.
- R7: A stage that drives its vector clears its pending flag at the next rising edge. Servicing takes precedence over a request arriving at that same edge, and the other stages' flags are left unchanged.
- R8: At most one bit of `vec_en` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all pending flags |
| dev_req | input | N_STAGES | Interrupt request per device; bit 0 is the device nearest the processor |
| cpu_ack | input | 1 | Processor acknowledge; this is the priority input of stage 0 |
| cpu_int | output | 1 | Combined interrupt line to the processor |
| vec_en | output | N_STAGES | One bit per stage, high on the stage that currently drives the vector |
| vec_bus | output | VEC_W | Vector placed on the shared bus by the winning stage |
| chain_tail | output | 1 | Priority output of the last stage |

## Verification
The bench builds the block with four stages, 8-bit vectors, VEC_BASE 32 and VEC_STEP 4. With four stages, all sixteen pending patterns can be swept, each one from reset. For every pattern, acknowledge is held until the chain drains. Each drain cycle is checked against the lowest remaining index and its computed vector, so both the priority order and the clearing of each winner are covered. Two further patterns check that a request held high during its own service is latched again once the service cycle is over.

// File: rtl/daisy_pkg.sv
package daisy_pkg;

    // Result of one stage's priority decision
    typedef struct packed {
        logic pass;   // token continues to next stage
        logic claim;  // this stage owns the acknowledge
    } prio_t;

    function automatic prio_t resolve(input logic prio_in, input logic pending);
        prio_t r;
        r.pass  = prio_in & ~pending;
        r.claim = prio_in & pending;
        return r;
    endfunction

    function automatic int slot_vector(input int idx, input int base, input int step);
        return base + idx * step;
    endfunction

endpackage

// File: rtl/daisy_stage.sv
module daisy_stage
    import daisy_pkg::*;
#(
    parameter int              VEC_W  = 8,
    parameter logic [VEC_W-1:0] MY_VEC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dev_req,
    input  logic             prio_in,
    output logic             prio_out,
    output logic             vec_en,
    output logic [VEC_W-1:0] vec_out,
    output logic             pending
);

    prio_t decision;

    always_comb begin
        decision = resolve(prio_in, pending);
        prio_out = decision.pass;
        vec_en   = decision.claim;
        vec_out  = MY_VEC;
    end

    // Service wins over a request arriving at the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (decision.claim) begin
            pending <= 1'b0;
        end else if (dev_req) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/vector_merge.sv
module vector_merge #(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8
) (
    input  logic [N_SRC-1:0][VEC_W-1:0] vecs,
    input  logic [N_SRC-1:0]            en,
    output logic [VEC_W-1:0]            bus
);

    always_comb begin
        bus = '0;
        for (int i = 0; i < N_SRC; i++) begin
            bus = bus | (vecs[i] & {VEC_W{en[i]}});
        end
    end

endmodule

// File: rtl/daisy_chain_irq.sv
module daisy_chain_irq
    import daisy_pkg::*;
#(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int VEC_STEP = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_STAGES-1:0] dev_req,
    input  logic                cpu_ack,
    output logic                cpu_int,
    output logic [N_STAGES-1:0] vec_en,
    output logic [VEC_W-1:0]    vec_bus,
    output logic                chain_tail
);

    localparam int LAST = N_STAGES - 1;

    logic [N_STAGES:0]               chain;
    logic [N_STAGES-1:0]             pend;
    logic [N_STAGES-1:0][VEC_W-1:0]  stage_vec;

    assign chain[0] = cpu_ack;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        daisy_stage #(
            .VEC_W  (VEC_W),
            .MY_VEC (VEC_W'(slot_vector(g, VEC_BASE, VEC_STEP)))
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .dev_req  (dev_req[g]),
            .prio_in  (chain[g]),
            .prio_out (chain[g+1]),
            .vec_en   (vec_en[g]),
            .vec_out  (stage_vec[g]),
            .pending  (pend[g])
        );
    end

    vector_merge #(
        .N_SRC (N_STAGES),
        .VEC_W (VEC_W)
    ) u_merge (
        .vecs (stage_vec),
        .en   (vec_en),
        .bus  (vec_bus)
    );

    assign cpu_int    = |pend;
    assign chain_tail = chain[LAST+1];

endmodule

// File: rtl/daisy_chain_irq_chk.sv
module daisy_chain_irq_chk #(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [N_STAGES-1:0] dev_req,
    input logic                cpu_ack,
    input logic                cpu_int,
    input logic [N_STAGES-1:0] vec_en,
    input logic [VEC_W-1:0]    vec_bus,
    input logic                chain_tail,
    input logic [N_STAGES-1:0] pend
);

    // R8
    a_r8_single_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vec_en));

    // R2
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cpu_ack |-> (vec_en == '0) && !chain_tail && (vec_bus == '0));

    // R3
    a_r3_empty_pass: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && !cpu_int) |-> chain_tail && (vec_bus == '0));

    // R4
    a_r4_claim_blocks_tail: assert property (@(posedge clk) disable iff (rst)
        (vec_en != '0) |-> !chain_tail);

    for (genvar k = 0; k < N_STAGES; k++) begin : g_chk
        // R7
        a_r7_served_clears: assert property (@(posedge clk) disable iff (rst)
            vec_en[k] |=> !pend[k]);
        // R1
        a_r1_request_latches: assert property (@(posedge clk) disable iff (rst)
            (dev_req[k] && !vec_en[k]) |=> pend[k]);
    end

endmodule

bind daisy_chain_irq daisy_chain_irq_chk #(
    .N_STAGES (N_STAGES),
    .VEC_W    (VEC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dev_req    (dev_req),
    .cpu_ack    (cpu_ack),
    .cpu_int    (cpu_int),
    .vec_en     (vec_en),
    .vec_bus    (vec_bus),
    .chain_tail (chain_tail),
    .pend       (pend)
);

// File: tb/sim_daisy_chain_irq.sv
`timescale 1ns/1ps
module sim_daisy_chain_irq;

    localparam int N  = 4;
    localparam int VW = 8;
    localparam int VB = 32;
    localparam int VS = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  dev_req;
    logic          cpu_ack;
    logic          cpu_int;
    logic [N-1:0]  vec_en;
    logic [VW-1:0] vec_bus;
    logic          chain_tail;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    daisy_chain_irq #(.N_STAGES(N), .VEC_W(VW), .VEC_BASE(VB), .VEC_STEP(VS)) u0 (
        .clk(clk), .rst(rst), .dev_req(dev_req), .cpu_ack(cpu_ack),
        .cpu_int(cpu_int), .vec_en(vec_en), .vec_bus(vec_bus), .chain_tail(chain_tail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lowest(input int m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; dev_req = '0; cpu_ack = 0;
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        rst = 1; dev_req = '0; cpu_ack = 0;
        do_reset();
        #1;
        chk(cpu_int == 0, "R6 reset int", int'(cpu_int), 0);
        chk(vec_en == 0,  "R2 reset en", int'(vec_en), 0);

        for (int p = 0; p < (1 << N); p++) begin
            int rem;
            do_reset();
            dev_req = N'(p);
            @(negedge clk);
            dev_req = '0;
            @(negedge clk);
            #1;
            // R1: flags held after request dropped; R6
            chk(cpu_int == (p != 0), "R1/R6 latched int", int'(cpu_int), int'(p != 0));
            chk(vec_en == 0 && !chain_tail && vec_bus == 0, "R2 ack low quiet",
                int'(vec_bus), 0);
            rem = p;
            @(negedge clk);
            cpu_ack = 1;
            while (rem != 0) begin
                int w;
                w = lowest(rem);
                #1;
                chk(vec_en == N'(1 << w), "R4 winner enable", int'(vec_en), 1 << w);
                chk(!chain_tail, "R4 tail blocked", int'(chain_tail), 0);
                chk(vec_bus == VW'(VB + w * VS), "R5 vector", int'(vec_bus), VB + w * VS);
                chk($countones(vec_en) <= 1, "R8 single owner", $countones(vec_en), 1);
                chk(cpu_int == 1, "R6 int pending", int'(cpu_int), 1);
                rem = rem & ~(1 << w);
                @(negedge clk);
            end
            #1;
            // R7: all served flags cleared; R3 pass-through
            chk(cpu_int == 0, "R7 drained", int'(cpu_int), 0);
            chk(chain_tail == 1, "R3 tail passes", int'(chain_tail), 1);
            chk(vec_bus == 0, "R3 bus empty", int'(vec_bus), 0);
            cpu_ack = 0;
        end

        // R7: request held through own service re-latches afterwards
        for (int s = 0; s < 2; s++) begin
            do_reset();
            dev_req = N'(1 << (s * 3));
            @(negedge clk);
            cpu_ack = 1;
            #1;
            chk(vec_en == N'(1 << (s * 3)), "R7 serviced stage", int'(vec_en), 1 << (s * 3));
            @(negedge clk);
            #1;
            chk(vec_en == 0, "R7 cleared while req held", int'(vec_en), 0);
            @(negedge clk);
            #1;
            chk(vec_en == N'(1 << (s * 3)), "R1 relatched", int'(vec_en), 1 << (s * 3));
            cpu_ack = 0; dev_req = '0;
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule